// File: doc/BRIEF.md
# Length-Prefixed Command Framing Engine

This block sits between a byte-wide host link and a command executor and handles one command transaction at a time. The first byte of a transaction is an opcode. A built-in size table gives, for each of the 256 opcodes, the number of parameter bytes that follow it and the number of reply bytes that go back. For either direction the table can give a fixed count or mark the count as carried in-band. A variable request starts with a length byte. A variable reply is preceded by a length byte that the block emits.

Parameter bytes are stored in a request buffer. The opcode and the stored length are then passed to the executor with a one-cycle start pulse. The executor reads parameters through a read port, writes its reply into a reply buffer, and raises done. The engine then streams the reply back to the host. Both byte streams use valid/ready. A byte moves on a rising clock edge where valid and ready are both high. The engine holds `out_valid` and `out_data` steady until `out_ready` is seen. The host may stall `in_valid` for any number of cycles.

Top module: `cmd_frame_engine`

## Requirements
- R1: After reset the block is idle: `in_ready`=1, `out_valid`=0, `exec_start`=0, `overflow`=0.
- R2: The fixed sizes are as follows (parameters in / reply out). 0x30 is 4/0. 0x38 is 0/4. 0x70, 0x10 and 0x11 are each 1/0. 0x7d is 5/1. 0x7e and 0x7f are each 4/1.
- R3: Opcode 0x33 has a variable request and no reply. Opcode 0x78 takes no parameters and has a variable reply. Opcode 0x3b takes 2 parameters and has a variable reply. For a variable request, the byte after the opcode is a length byte giving the number of parameter bytes that follow.
- R4: For a variable reply, the engine first emits a length byte equal to the reply count, then the reply bytes.
- R5: Parameter bytes are stored in arrival order starting at index 0 and can be read at `exec_rd_addr`. When `exec_start` is high, `exec_opcode` holds the opcode and `exec_param_len` holds the number of bytes stored.
- R6: `exec_start` is high for exactly one cycle. For a zero-length request it rises in the cycle right after the opcode is accepted.
- R7: After done, the reply is sent from reply buffer index 0 upward, in order. Under back-pressure, `out_valid` stays high and `out_data` stays unchanged.
- R8: For a fixed reply size of 0, the engine returns to idle when done is seen and never raises `out_valid`.
- R9: A request length byte above 128 is clamped to 128 stored bytes. The extra bytes are still accepted and then dropped, and the sticky `overflow` flag is set. A variable reply count above 128 is clamped to 128 in the same way.
- R10: No opcode is accepted while a command is being executed or a reply is being sent. `in_ready` is 0 in those phases and is never high together with `out_valid`.
- R11: `abort` returns the block to idle on the next clock edge from any phase. The next input byte is then taken as an opcode.
- R12: Each opcode not named in R2 or R3 has a variable request. Its reply is variable if opcode bit 3 is 1 and empty otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| abort | input | 1 | Synchronous return to idle |
| in_valid | input | 1 | Host byte valid |
| in_ready | output | 1 | Engine accepts a host byte |
| in_data | input | 8 | Host byte |
| out_valid | output | 1 | Reply byte valid |
| out_ready | input | 1 | Host accepts a reply byte |
| out_data | output | 8 | Reply byte |
| exec_start | output | 1 | One-cycle start pulse to executor |
| exec_opcode | output | 8 | Opcode of current command |
| exec_param_len | output | 8 | Number of stored parameter bytes |
| exec_rd_addr | input | 7 | Parameter buffer read index |
| exec_rd_data | output | 8 | Parameter byte at read index |
| exec_wr_en | input | 1 | Reply buffer write enable |
| exec_wr_addr | input | 7 | Reply buffer write index |
| exec_wr_data | input | 8 | Reply buffer write byte |
| exec_reply_len | input | 8 | Reply count for variable replies |
| exec_done | input | 1 | Executor finished |
| overflow | output | 1 | Sticky clamp indicator |

## Verification
The bench covers four framing corner cases:
- A zero-length request. A wrong design waits for a parameter byte that never comes, so `exec_start` does not rise.
- A 130-byte variable request. A design without the clamp would wrap the buffer index, overwrite byte 0 and report the wrong length. A design that stops accepting the extra bytes would stall the host.
- Variable replies with a count of zero and with a count above 128. A bad length byte or a missing clamp shows up directly in the first reply byte.
- An abort in the middle of parameters and in the middle of a reply. A design that keeps stale counters would treat the next opcode as a parameter.

// File: rtl/cfe_pkg.sv
package cfe_pkg;
  localparam int BYTE_W = 8;

  typedef struct packed {
    logic              in_var;
    logic [BYTE_W-1:0] in_fix;
    logic              out_var;
    logic [BYTE_W-1:0] out_fix;
  } size_desc_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEN,
    ST_PARAM,
    ST_EXEC,
    ST_RLEN,
    ST_REPLY
  } frame_state_t;

  function automatic logic [BYTE_W-1:0] clamp_len(input logic [BYTE_W-1:0] n,
                                                   input logic [BYTE_W-1:0] lim);
    return (n > lim) ? lim : n;
  endfunction
endpackage

// File: rtl/cfe_size_lookup.sv
module cfe_size_lookup
  import cfe_pkg::*;
(
  input  logic [BYTE_W-1:0] opcode,
  output size_desc_t        desc
);
  always_comb begin
    // opcodes outside the list: variable request, reply variable when bit 3 set
    desc = '{in_var: 1'b1, in_fix: '0, out_var: opcode[3], out_fix: '0};
    case (opcode)
      8'h10, 8'h11, 8'h70: desc = '{1'b0, 8'd1, 1'b0, 8'd0};
      8'h30:               desc = '{1'b0, 8'd4, 1'b0, 8'd0};
      8'h38:               desc = '{1'b0, 8'd0, 1'b0, 8'd4};
      8'h78:               desc = '{1'b0, 8'd0, 1'b1, 8'd0};
      8'h7d:               desc = '{1'b0, 8'd5, 1'b0, 8'd1};
      8'h7e, 8'h7f:        desc = '{1'b0, 8'd4, 1'b0, 8'd1};
      8'h33:               desc = '{1'b1, 8'd0, 1'b0, 8'd0};
      8'h3b:               desc = '{1'b0, 8'd2, 1'b1, 8'd0};
      default: ;
    endcase
  end
endmodule

// File: rtl/cfe_byte_buf.sv
module cfe_byte_buf #(
  parameter int DEPTH = 128,
  parameter int W     = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_data
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/cmd_frame_engine.sv
module cmd_frame_engine
  import cfe_pkg::*;
#(
  parameter int BUF_DEPTH = 128,
  localparam int IDX_W    = $clog2(BUF_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              abort,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [7:0]        out_data,
  output logic              exec_start,
  output logic [7:0]        exec_opcode,
  output logic [7:0]        exec_param_len,
  input  logic [IDX_W-1:0]  exec_rd_addr,
  output logic [7:0]        exec_rd_data,
  input  logic              exec_wr_en,
  input  logic [IDX_W-1:0]  exec_wr_addr,
  input  logic [7:0]        exec_wr_data,
  input  logic [7:0]        exec_reply_len,
  input  logic              exec_done,
  output logic              overflow
);
  localparam logic [7:0] DEPTH_B = 8'(BUF_DEPTH);

  frame_state_t state;
  size_desc_t   desc;
  logic [7:0]   op_q, rx_total, keep, cnt, rlen, rcnt;
  logic         out_var_q, start_q, ovf_q;
  logic [7:0]   out_fix_q, rsp_byte;
  logic         prm_we;

  cfe_size_lookup u_lookup (.opcode(in_data), .desc(desc));

  assign prm_we = (state == ST_PARAM) && in_valid && !abort && (cnt < keep);

  cfe_byte_buf #(.DEPTH(BUF_DEPTH), .W(8)) u_prm_buf (
    .clk(clk), .wr_en(prm_we), .wr_addr(cnt[IDX_W-1:0]), .wr_data(in_data),
    .rd_addr(exec_rd_addr), .rd_data(exec_rd_data));

  cfe_byte_buf #(.DEPTH(BUF_DEPTH), .W(8)) u_rsp_buf (
    .clk(clk), .wr_en(exec_wr_en), .wr_addr(exec_wr_addr), .wr_data(exec_wr_data),
    .rd_addr(rcnt[IDX_W-1:0]), .rd_data(rsp_byte));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      op_q      <= '0;
      rx_total  <= '0;
      keep      <= '0;
      cnt       <= '0;
      rlen      <= '0;
      rcnt      <= '0;
      out_var_q <= 1'b0;
      out_fix_q <= '0;
      start_q   <= 1'b0;
      ovf_q     <= 1'b0;
    end else begin
      start_q <= 1'b0;
      if (abort) begin
        state <= ST_IDLE;
        cnt   <= '0;
        rcnt  <= '0;
      end else begin
        case (state)
          ST_IDLE: if (in_valid) begin
            op_q      <= in_data;
            out_var_q <= desc.out_var;
            out_fix_q <= desc.out_fix;
            cnt       <= '0;
            if (desc.in_var) begin
              state <= ST_LEN;
            end else if (desc.in_fix != 8'd0) begin
              rx_total <= desc.in_fix;
              keep     <= clamp_len(desc.in_fix, DEPTH_B);
              state    <= ST_PARAM;
            end else begin
              keep    <= '0;
              state   <= ST_EXEC;
              start_q <= 1'b1;
            end
          end
          ST_LEN: if (in_valid) begin
            rx_total <= in_data;
            keep     <= clamp_len(in_data, DEPTH_B);
            if (in_data > DEPTH_B) ovf_q <= 1'b1;
            if (in_data == 8'd0) begin
              state   <= ST_EXEC;
              start_q <= 1'b1;
            end else begin
              state <= ST_PARAM;
            end
          end
          ST_PARAM: if (in_valid) begin
            cnt <= cnt + 8'd1;
            if (cnt == rx_total - 8'd1) begin
              state   <= ST_EXEC;
              start_q <= 1'b1;
            end
          end
          ST_EXEC: if (exec_done && !start_q) begin
            rcnt <= '0;
            if (out_var_q) begin
              rlen  <= clamp_len(exec_reply_len, DEPTH_B);
              if (exec_reply_len > DEPTH_B) ovf_q <= 1'b1;
              state <= ST_RLEN;
            end else begin
              rlen  <= clamp_len(out_fix_q, DEPTH_B);
              state <= (out_fix_q == 8'd0) ? ST_IDLE : ST_REPLY;
            end
          end
          ST_RLEN: if (out_ready) begin
            state <= (rlen == 8'd0) ? ST_IDLE : ST_REPLY;
          end
          ST_REPLY: if (out_ready) begin
            rcnt <= rcnt + 8'd1;
            if (rcnt == rlen - 8'd1) state <= ST_IDLE;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  assign in_ready       = (state == ST_IDLE) || (state == ST_LEN) || (state == ST_PARAM);
  assign out_valid      = (state == ST_RLEN) || (state == ST_REPLY);
  assign out_data       = (state == ST_RLEN) ? rlen : rsp_byte;
  assign exec_start     = start_q;
  assign exec_opcode    = op_q;
  assign exec_param_len = keep;
  assign overflow       = ovf_q;
endmodule

// File: rtl/cfe_checker.sv
module cfe_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       abort,
  input logic       in_ready,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data,
  input logic       exec_start,
  input logic [7:0] exec_param_len,
  input logic       overflow
);
  a_r6_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    exec_start |=> !exec_start);

  a_r7_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !abort) |=> (out_valid && $stable(out_data)));

  a_r10_one_direction: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));

  a_r10_no_input_in_exec: assert property (@(posedge clk) disable iff (!rst_n)
    exec_start |-> !in_ready);

  a_r9_sticky_flag: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  a_r9_len_bound: assert property (@(posedge clk) disable iff (!rst_n)
    exec_start |-> (exec_param_len <= 8'd128));

  a_r11_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (in_ready && !out_valid && !exec_start));
endmodule

bind cmd_frame_engine cfe_checker u_cfe_checker (
  .clk(clk), .rst_n(rst_n), .abort(abort), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .exec_start(exec_start), .exec_param_len(exec_param_len), .overflow(overflow));

// File: tb/cmd_frame_engine_tb_top.sv
module cmd_frame_engine_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       abort = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = '0;
  logic       out_valid;
  logic       out_ready = 1'b0;
  logic [7:0] out_data;
  logic       exec_start;
  logic [7:0] exec_opcode, exec_param_len, exec_rd_data;
  logic [6:0] exec_rd_addr = '0;
  logic       exec_wr_en = 1'b0;
  logic [6:0] exec_wr_addr = '0;
  logic [7:0] exec_wr_data = '0;
  logic [7:0] exec_reply_len = '0;
  logic       exec_done = 1'b0;
  logic       overflow;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  cmd_frame_engine dut_i (.*);

  typedef struct packed {
    logic in_var; logic [7:0] in_fix; logic out_var; logic [7:0] out_fix;
  } exp_t;

  // sizes written down from R2, R3, R12
  function automatic exp_t exp_sizes(input logic [7:0] op);
    case (op)
      8'h10, 8'h11, 8'h70: return '{1'b0, 8'd1, 1'b0, 8'd0};
      8'h30:               return '{1'b0, 8'd4, 1'b0, 8'd0};
      8'h38:               return '{1'b0, 8'd0, 1'b0, 8'd4};
      8'h78:               return '{1'b0, 8'd0, 1'b1, 8'd0};
      8'h7d:               return '{1'b0, 8'd5, 1'b0, 8'd1};
      8'h7e, 8'h7f:        return '{1'b0, 8'd4, 1'b0, 8'd1};
      8'h33:               return '{1'b1, 8'd0, 1'b0, 8'd0};
      8'h3b:               return '{1'b0, 8'd2, 1'b1, 8'd0};
      default:             return '{1'b1, 8'd0, op[3], 8'd0};
    endcase
  endfunction

  typedef struct packed { logic [7:0] op; logic [7:0] nreq; logic [7:0] nrep; } vec_t;
  localparam vec_t VECS [12] = '{
    '{8'h30, 8'd0, 8'd0}, '{8'h38, 8'd0, 8'd0}, '{8'h70, 8'd0, 8'd0},
    '{8'h78, 8'd0, 8'd3}, '{8'h7d, 8'd0, 8'd0}, '{8'h7e, 8'd0, 8'd0},
    '{8'h7f, 8'd0, 8'd0}, '{8'h10, 8'd0, 8'd0}, '{8'h33, 8'd6, 8'd0},
    '{8'h3b, 8'd0, 8'd5}, '{8'h55, 8'd2, 8'd0}, '{8'h4a, 8'd1, 8'd2}};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = b;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic recv_byte(output logic [7:0] b);
    @(negedge clk);
    out_ready = 1'b1;
    while (!out_valid) @(negedge clk);
    b = out_data;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic run_txn(input logic [7:0] op, input logic [7:0] nreq, input logic [7:0] nrep);
    exp_t e;
    int n, m, kept;
    logic [7:0] b;
    e = exp_sizes(op);
    send_byte(op);
    if (e.in_var) begin
      send_byte(nreq);
      n = nreq;
    end else n = e.in_fix;
    for (int i = 0; i < n; i++) send_byte(op ^ 8'(i + 1));
    while (!exec_start) @(negedge clk);
    kept = (n > 128) ? 128 : n;
    chk(exec_opcode == op, "R5 opcode", exec_opcode, op);
    chk(exec_param_len == 8'(kept), e.in_var ? "R3 var request length" : "R2 request size",
        exec_param_len, kept);
    chk(!in_ready, "R10 no input during exec", in_ready, 0);
    for (int i = 0; i < kept; i++) begin
      exec_rd_addr = 7'(i);
      #1;
      if (exec_rd_data != (op ^ 8'(i + 1)))
        chk(1'b0, "R5 param byte", exec_rd_data, op ^ 8'(i + 1));
    end
    m = e.out_var ? nrep : e.out_fix;
    for (int i = 0; i < m; i++) begin
      @(negedge clk);
      exec_wr_en = 1'b1; exec_wr_addr = 7'(i); exec_wr_data = 8'hA0 + 8'(i);
    end
    @(negedge clk);
    exec_wr_en = 1'b0;
    exec_reply_len = 8'(nrep);
    exec_done = 1'b1;
    @(negedge clk);
    exec_done = 1'b0;
    if (m == 0 && !e.out_var)
      chk(!out_valid && in_ready, "R8 empty reply to idle", out_valid, 0);
    if (e.out_var) begin
      recv_byte(b);
      chk(b == 8'(m), "R4 reply length byte", b, m);
    end
    for (int i = 0; i < m; i++) begin
      recv_byte(b);
      chk(b == 8'hA0 + 8'(i), e.out_var ? "R4 reply data" : "R7 reply data", b, 8'hA0 + i);
    end
    @(negedge clk);
    chk(in_ready && !out_valid, "R10 back to idle", in_ready, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0] b, b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(in_ready && !out_valid && !exec_start && !overflow, "R1 reset idle", in_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready && !out_valid && !overflow, "R1 idle after reset", out_valid, 0);

    foreach (VECS[k]) run_txn(VECS[k].op, VECS[k].nreq, VECS[k].nrep);

    // R12: unlisted opcode with bit 3 clear gives no reply after a zero-length request
    run_txn(8'h62, 8'd0, 8'd0);

    // R6: zero-length request starts in the cycle after the opcode
    send_byte(8'h38);
    chk(exec_start, "R6 immediate start", exec_start, 1);
    @(negedge clk);
    chk(!exec_start, "R6 single pulse", exec_start, 0);
    abort = 1'b1; @(negedge clk); abort = 1'b0;

    // R7: back-pressure holds the reply byte
    send_byte(8'h78);
    while (!exec_start) @(negedge clk);
    @(negedge clk);
    exec_wr_en = 1'b1; exec_wr_addr = 7'd0; exec_wr_data = 8'h5C;
    @(negedge clk);
    exec_wr_en = 1'b0; exec_reply_len = 8'd1; exec_done = 1'b1;
    @(negedge clk);
    exec_done = 1'b0;
    b0 = out_data;
    repeat (2) @(negedge clk);
    chk(out_valid && out_data == b0, "R7 stall holds byte", out_data, b0);
    recv_byte(b);
    chk(b == 8'd1, "R4 length byte after stall", b, 1);
    recv_byte(b);
    chk(b == 8'h5C, "R7 data after stall", b, 8'h5C);

    // R4: variable reply of zero bytes
    run_txn(8'h78, 8'd0, 8'd0);

    // R9: 130-byte request clamps to 128, flag set
    chk(!overflow, "R9 flag clear before", overflow, 0);
    run_txn(8'h33, 8'd130, 8'd0);
    chk(overflow, "R9 overflow sticky", overflow, 1);

    // R11: abort mid-parameters, next byte is an opcode
    send_byte(8'h30);
    send_byte(8'h01);
    send_byte(8'h02);
    @(negedge clk); abort = 1'b1; @(negedge clk); abort = 1'b0;
    chk(in_ready && !exec_start, "R11 abort in params", in_ready, 1);
    send_byte(8'h38);
    chk(exec_start && exec_opcode == 8'h38, "R11 new opcode after abort", exec_opcode, 8'h38);

    // R9 reply clamp, then R11 abort during reply
    @(negedge clk);
    exec_reply_len = 8'd0; exec_done = 1'b1; @(negedge clk); exec_done = 1'b0;
    for (int i = 0; i < 4; i++) recv_byte(b);
    send_byte(8'h78);
    while (!exec_start) @(negedge clk);
    @(negedge clk);
    exec_reply_len = 8'd200; exec_done = 1'b1; @(negedge clk); exec_done = 1'b0;
    recv_byte(b);
    chk(b == 8'd128, "R9 reply clamp", b, 128);
    chk(out_valid, "R9 reply streaming", out_valid, 1);
    abort = 1'b1; @(negedge clk); abort = 1'b0;
    chk(!out_valid && in_ready, "R11 abort in reply", out_valid, 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule